// File: doc/BRIEF.md
# Serial-Bus Video Control Register Bank

This block is a write-only I2C target that holds the thirteen 8-bit settings of a three-channel video amplifier path. These are gain and level trims, per-channel cut-off trims, and two switch registers whose flag bits steer blanking, clamping, half-tone and the OSD raster colour. A host writes the bank over SCL/SDA. The block samples both lines with its own system clock, which runs much faster than SCL. It finds START and STOP from SDA edges while SCL is high, and pulls SDA low to acknowledge every byte of a transfer addressed to it.

After the address byte the host sends a sub-address and a data byte, and may repeat such pairs before STOP. A sub-address whose top bit is set and whose low nibble is zero starts a burst instead. In a burst every following byte is data, and the data goes to registers 0x00, 0x01 and onward. Every register is driven out in parallel. The flag bits are also brought out as separate signals.

Top module: `vid_i2c_regbank`

## Requirements
- R1: After reset, registers 0x00 to 0x09 hold 0x80, registers 0x0A and 0x0B hold 0x00, and register 0x0C holds 0x0F. Register n occupies bits [8n+7:8n] of `reg_flat`.
- R2: The block acknowledges an address byte only when it equals 0xDC (target address 0x6E followed by a write bit of 0). After any other address byte it leaves SDA released and writes nothing until the next START.
- R3: An acknowledge holds `sda_oe` high from the SCL falling edge that ends the eighth bit until the SCL falling edge that ends the ninth bit. The block acknowledges the address, sub-address and data bytes.
- R4: Bytes are received MSB first. START, address, sub-address and one data byte, followed by STOP, store that data byte in the addressed register.
- R5: Several sub-address/data pairs in one transaction are each written to their own register.
- R6: A sub-address with bit 7 set and bits 3:0 clear selects burst mode. The following data bytes go to 0x00, 0x01, 0x02 and so on, one register per byte.
- R7: A data byte aimed at a sub-address above 0x0C, whether from a plain write or from a burst that runs past 0x0C, is acknowledged and discarded. No register changes.
- R8: A START seen in the middle of a byte drops the partly received byte and restarts address reception.
- R9: The decoded outputs follow fixed bit positions. In 0x0A, bit 0 is half-tone enable, bits 3:1 are raster 1 (red, green, blue from bit 1 upward) and bits 6:4 are raster 2. In 0x0B, bit 0 is soft blank, bit 1 is blank polarity, bit 2 is cut-off external select, bits 3 and 4 are the two cut-off offsets, and bit 5 is clamp polarity. In 0x0C, bits 3:0 are test bits and bits 6:4 are raster 3.
- R10: Register contents change only in the clock after a synchronised SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data from the bus |
| sda_oe | output | 1 | High to pull SDA low (acknowledge) |
| reg_flat | output | 104 | All thirteen registers, register n at [8n+7:8n] |
| halftone_en | output | 1 | Half-tone enable |
| raster1 | output | 3 | Raster 1 colour {blue, green, red} |
| raster2 | output | 3 | Raster 2 colour {blue, green, red} |
| raster3 | output | 3 | Raster 3 colour {blue, green, red} |
| soft_blank | output | 1 | Soft blank switch |
| blank_pol | output | 1 | Blank input polarity |
| cutoff_ext | output | 1 | Cut-off internal/external select |
| cut_ofs1 | output | 1 | Cut-off offset 1 |
| cut_ofs2 | output | 1 | Cut-off offset 2 |
| clamp_pol | output | 1 | Clamp input polarity |
| test_bits | output | 4 | Test bits |

## Verification
The bench sends addresses that differ from 0xDC by a single bit, including the read bit. A block that matched too loosely would acknowledge these and take the data bytes after them. Bursts of random length run past 0x0C, and plain writes go to sub-addresses 0x0D to 0x0F. A pointer that wrapped or was truncated would overwrite low registers there. A START injected after half a data byte would, if mishandled, store a shifted byte. Random pair streams check that a block does not lose track of the alternation between sub-address and data.

// File: rtl/vid_i2c_regbank.sv
module vid_i2c_regbank #(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter int NREG = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_flat,
  output logic              halftone_en,
  output logic [2:0]        raster1,
  output logic [2:0]        raster2,
  output logic [2:0]        raster3,
  output logic              soft_blank,
  output logic              blank_pol,
  output logic              cutoff_ext,
  output logic              cut_ofs1,
  output logic              cut_ofs2,
  output logic              clamp_pol,
  output logic [3:0]        test_bits
);
  localparam int LVL_COUNT = 10;
  localparam int HT_IDX = 10;
  localparam int SW_IDX = 11;
  localparam int TST_IDX = 12;
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

  typedef enum logic [1:0] {P_IDLE, P_ADDR, P_SUB, P_DATA} phase_t;

  function automatic logic [7:0] rst_val(int i);
    if (i == TST_IDX) return 8'h0F;
    else if (i >= LVL_COUNT) return 8'h00;
    else return 8'h80;
  endfunction

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;
  phase_t phase;
  logic [7:0] shreg, ptr;
  logic [3:0] bitcnt;
  logic ack, burst, wr_en, bus_idle;
  logic [7:0] regs [NREG];

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det = scl_s & scl_d & ~sda_d & sda_s;
  assign byte_done = scl_fall & ~ack & (bitcnt == 4'd8);
  assign wr_en = byte_done & (phase == P_DATA) & ~start_det & ~stop_det;
  assign bus_idle = (phase == P_IDLE);
  assign sda_oe = ack;

  logic byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      shreg <= '0;
      ptr <= '0;
      bitcnt <= '0;
      ack <= 1'b0;
      burst <= 1'b0;
    end else if (start_det) begin
      phase <= P_ADDR;
      bitcnt <= '0;
      ack <= 1'b0;
      burst <= 1'b0;
    end else if (stop_det) begin
      phase <= P_IDLE;
      ack <= 1'b0;
      burst <= 1'b0;
    end else if (phase != P_IDLE) begin
      if (scl_rise && !ack && bitcnt < 4'd8) begin
        shreg <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && ack) begin
        ack <= 1'b0;
        bitcnt <= '0;
      end else if (byte_done) begin
        case (phase)
          P_ADDR: begin
            if (shreg == ADDR_BYTE) begin
              ack <= 1'b1;
              phase <= P_SUB;
            end else begin
              phase <= P_IDLE;
            end
          end
          P_SUB: begin
            ack <= 1'b1;
            phase <= P_DATA;
            if (shreg[7] && shreg[3:0] == 4'h0) begin
              burst <= 1'b1;
              ptr <= '0;
            end else begin
              burst <= 1'b0;
              ptr <= shreg;
            end
          end
          default: begin
            ack <= 1'b1;
            if (burst) begin
              if (ptr != 8'hFF) ptr <= ptr + 8'd1;
            end else begin
              phase <= P_SUB;
            end
          end
        endcase
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i] <= rst_val(i);
      else if (wr_en && ptr == 8'(i)) regs[i] <= shreg;
    end
    assign reg_flat[8*i +: 8] = regs[i];
  end

  assign halftone_en = regs[HT_IDX][0];
  assign raster1 = regs[HT_IDX][3:1];
  assign raster2 = regs[HT_IDX][6:4];
  assign raster3 = regs[TST_IDX][6:4];
  assign test_bits = regs[TST_IDX][3:0];
  assign soft_blank = regs[SW_IDX][0];
  assign blank_pol = regs[SW_IDX][1];
  assign cutoff_ext = regs[SW_IDX][2];
  assign cut_ofs1 = regs[SW_IDX][3];
  assign cut_ofs2 = regs[SW_IDX][4];
  assign clamp_pol = regs[SW_IDX][5];
endmodule

// File: rtl/vid_i2c_regbank_chk.sv
module vid_i2c_regbank_chk #(
  parameter int NREG = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              scl_d,
  input logic              sda_s,
  input logic              sda_d,
  input logic              bus_idle,
  input logic              sda_oe,
  input logic [NREG*8-1:0] reg_flat
);
  logic fall_seen, stop_seen;
  assign fall_seen = ~scl_s & scl_d;
  assign stop_seen = scl_s & scl_d & ~sda_d & sda_s;

  assert_ack_begins_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_ack_ends_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);

  assert_write_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_flat) |-> $past(fall_seen));

  assert_no_write_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_idle) && bus_idle |-> $stable(reg_flat));
endmodule

bind vid_i2c_regbank vid_i2c_regbank_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_d(scl_d), .sda_s(sda_s),
  .sda_d(sda_d), .bus_idle(bus_idle), .sda_oe(sda_oe), .reg_flat(reg_flat)
);

// File: tb/vid_i2c_regbank_test.sv
module vid_i2c_regbank_test;
  localparam int NREG = 13;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] reg_flat;
  logic halftone_en, soft_blank, blank_pol, cutoff_ext, cut_ofs1, cut_ofs2, clamp_pol;
  logic [2:0] raster1, raster2, raster3;
  logic [3:0] test_bits;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  vid_i2c_regbank uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_flat(reg_flat), .halftone_en(halftone_en), .raster1(raster1),
    .raster2(raster2), .raster3(raster3), .soft_blank(soft_blank),
    .blank_pol(blank_pol), .cutoff_ext(cutoff_ext), .cut_ofs1(cut_ofs1),
    .cut_ofs2(cut_ofs2), .clamp_pol(clamp_pol), .test_bits(test_bits)
  );

  function automatic logic [7:0] reset_of(int i);
    if (i == 12) return 8'h0F;
    if (i >= 10) return 8'h00;
    return 8'h80;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int k = 7; k > 7 - n; k--) begin
      wait_clk(Q); sda_m = b[k];
      wait_clk(Q); scl_m = 1'b1;
      wait_clk(2*Q); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    wait_clk(Q); sda_m = 1'b1;
    wait_clk(Q); scl_m = 1'b1;
    wait_clk(Q); acked = !sda_line;
    wait_clk(Q); scl_m = 1'b0;
  endtask

  task automatic cmp_model(input string req);
    bit ok = 1;
    int bad = 0;
    for (int i = 0; i < NREG; i++)
      if (reg_flat[8*i +: 8] !== model[i] && ok) begin ok = 0; bad = i; end
    chk(ok, req, {bad[7:0], 16'h0, reg_flat[8*bad +: 8]}, {bad[7:0], 16'h0, model[bad]});
  endtask

  task automatic write_pair(input logic [7:0] sub, input logic [7:0] d, input string req);
    bit a;
    i2c_start;
    send_byte(8'hDC, a); chk(a, "R2 addr ack", a, 1);
    send_byte(sub, a); chk(a, "R3 sub ack", a, 1);
    send_byte(d, a); chk(a, "R7 data ack", a, 1);
    i2c_stop;
    if (sub < NREG) model[sub] = d;
    cmp_model(req);
  endtask

  task automatic burst(input int n);
    bit a;
    bit all = 1;
    i2c_start;
    send_byte(8'hDC, a);
    send_byte({1'b1, 3'($urandom), 4'h0}, a);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'($urandom);
      send_byte(d, a);
      all &= a;
      if (k < NREG) model[k] = d;
    end
    i2c_stop;
    chk(all, "R7 burst ack", all, 1);
    cmp_model(n > NREG ? "R7 burst overrun" : "R6 burst");
  endtask

  initial begin
    bit a;
    void'($urandom(32'd4517));
    for (int i = 0; i < NREG; i++) model[i] = reset_of(i);
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    cmp_model("R1 reset");
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);

    write_pair(8'h03, 8'hA5, "R4 single write");

    // R3: acknowledge window released after ninth falling edge
    i2c_start;
    send_byte(8'hDC, a);
    wait_clk(Q);
    chk(sda_oe == 1'b0, "R3 release after ack", sda_oe, 0);
    send_byte(8'h05, a);
    send_byte(8'h3C, a);
    i2c_stop;
    model[5] = 8'h3C;
    cmp_model("R3 write");

    // R2: near-miss addresses
    foreach (model[i]) ;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] bad = 8'hDC ^ (8'h1 << k);
      i2c_start;
      send_byte(bad, a); chk(!a, "R2 wrong addr nack", a, 0);
      send_byte(8'h01, a); chk(!a, "R2 ignored after mismatch", a, 0);
      send_byte(8'h11, a);
      i2c_stop;
      cmp_model("R2 no write");
    end

    // R5: several pairs
    i2c_start;
    send_byte(8'hDC, a);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] s = 8'($urandom_range(0, 12));
      logic [7:0] d = 8'($urandom);
      send_byte(s, a); send_byte(d, a);
      model[s] = d;
    end
    i2c_stop;
    cmp_model("R5 multi pair");

    // R7: out-of-range plain writes
    for (int s = 13; s < 16; s++) write_pair(8'(s), 8'h5A, "R7 discard");

    // R8: START in mid byte
    i2c_start;
    send_byte(8'hDC, a);
    send_byte(8'h02, a);
    send_bits(8'hF0, 4);
    i2c_start;
    send_byte(8'hDC, a); chk(a, "R8 restart addr ack", a, 1);
    send_byte(8'h06, a);
    send_byte(8'h77, a);
    i2c_stop;
    model[6] = 8'h77;
    cmp_model("R8 restart");

    burst(1);
    burst(NREG);
    burst(NREG + 4);

    for (int t = 0; t < 30; t++)
      write_pair(8'($urandom_range(0, 15)), 8'($urandom), "R4 random write");

    burst($urandom_range(2, 16));

    write_pair(8'h0A, 8'h5B, "R9 set 0A");
    write_pair(8'h0B, 8'h2D, "R9 set 0B");
    write_pair(8'h0C, 8'h6A, "R9 set 0C");
    chk({halftone_en, raster1, raster2} == {model[10][0], model[10][3:1], model[10][6:4]},
        "R9 0A decode", {halftone_en, raster1, raster2}, {model[10][0], model[10][3:1], model[10][6:4]});
    chk({soft_blank, blank_pol, cutoff_ext, cut_ofs1, cut_ofs2, clamp_pol} ==
        {model[11][0], model[11][1], model[11][2], model[11][3], model[11][4], model[11][5]},
        "R9 0B decode", {soft_blank, blank_pol, cutoff_ext, cut_ofs1, cut_ofs2, clamp_pol}, model[11][5:0]);
    chk({raster3, test_bits} == model[12][6:0], "R9 0C decode", {raster3, test_bits}, model[12][6:0]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule